// File: doc/BRIEF.md
# Serial I/Q Baseband Deserializer

This block sits at the receive edge of a baseband path and turns a serial complex-sample stream from a tuner into parallel I/Q pairs. The link carries a bit clock, a word strobe and two data lines, `sd_i` and `sd_q`. The block runs directly on the bit clock. It collects one 16-bit signed I word and the matching 16-bit signed Q word, and presents both together with a single-cycle valid pulse. Sample-rate conversion, filtering and the transfer into the core clock domain are handled downstream.

Three framings are supported, selected by `mode_sel`:
- **Split (code 0):** I and Q travel on their own pins at the same time.
- **Multiplexed (code 1):** both words share the I pin and are told apart by the direction of the strobe edge.
- **Single-pulse (code 2):** a one-bit-wide strobe pulse starts an I word, and the Q word follows on the I pin with no gap.

A start marker that arrives in the middle of a word is reported on a sticky framing-error flag. A second instance that carries data only can set `data_only` to turn that reporting off. Both `mode_sel` and `data_only` are captured only while the synchronous reset is held.

The block counts bit-clock periods only. Its behaviour is the same at every supported sample rate (650 to 912 kS/s), because the bit clock always gives 32 periods per pair.

Top module: `bbrx_rx`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears `pair_valid`, `pair_i`, `pair_q` and `frame_err` to zero.
- R2: In split mode (`mode_sel` 0, and also the spare code 3), either edge of `ws` starts a pair. The bit sampled on the edge where the strobe change is first seen is the MSB. I is taken from `sd_i` and Q from `sd_q`, 16 bits each, MSB first. The pair is presented after the 16th bit.
- R3: In multiplexed mode (`mode_sel` 1), a falling `ws` edge starts a 16-bit I word on `sd_i` and a rising edge starts a 16-bit Q word on `sd_i`. The pair is presented after the 16th Q bit.
- R4: In single-pulse mode (`mode_sel` 2), `ws` seen high after being low starts the I word on `sd_i`. The Q word follows on the next 16 bit periods with no further marker, and the pair is presented after the 32nd bit.
- R5: `pair_valid` is high for exactly one clock cycle, in the cycle after the edge that samples a pair's last bit. It is not raised when only the I word is complete. `pair_i`/`pair_q` change only together with that pulse.
- R6: A start marker that arrives before the current word has all 16 bits discards the partial pair. It sets `frame_err`, which stays set until reset, and it begins a fresh word with the bit sampled on that edge.
- R7: In multiplexed mode, a Q word that has no completed I word before it is dropped, and no pair is presented.
- R8: When `data_only` is captured as 1, `frame_err` never asserts. Decoding is otherwise unchanged.
- R9: `mode_sel` and `data_only` are sampled only while `rst` is high. Changing them after reset has no effect on decoding or error reporting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock; data and strobe sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high; also captures configuration |
| mode_sel | input | 2 | Framing select: 0 split, 1 multiplexed, 2 single-pulse, 3 as split |
| data_only | input | 1 | 1 = suppress framing-error reporting |
| ws | input | 1 | Word strobe from the tuner |
| sd_i | input | 1 | Serial I data (both words in modes 1 and 2) |
| sd_q | input | 1 | Serial Q data (split mode only) |
| pair_valid | output | 1 | One-cycle pulse when a new pair is presented |
| pair_i | output | 16 | Last complete I word, signed |
| pair_q | output | 16 | Last complete Q word, signed |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
A pair becomes visible one bit-clock edge after the final bit is sampled. In split mode that is the edge taking the 16th bit. In the other two modes it is the edge taking the 32nd bit. `frame_err` rises on the edge that samples the offending marker.

The bench changes inputs on the falling edge. After the last data bit it waits for exactly one falling edge and reads the pair there. It checks that `pair_valid` has dropped one cycle later. The multiplexed sequences are also sampled in the cycle after the I word completes, which shows that no early pulse appears.

// File: rtl/bbrx_pkg.sv
package bbrx_pkg;

    typedef enum logic [1:0] {
        FRM_SPLIT = 2'd0,
        FRM_MUX   = 2'd1,
        FRM_PULSE = 2'd2,
        FRM_ALT   = 2'd3
    } frm_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_I    = 2'd1,
        PH_Q    = 2'd2
    } phase_e;

endpackage

// File: rtl/bbrx_marker.sv
// Strobe edge detection and decode of word-start markers per framing.
module bbrx_marker
    import bbrx_pkg::*;
(
    input  logic      clk,
    input  frm_mode_e mode,
    input  logic      ws,
    output logic      start_i,
    output logic      start_q
);

    logic ws_d, ws_q;
    logic rise, fall;

    always_comb begin
        ws_d    = ws;
        rise    = ws & ~ws_q;
        fall    = ~ws & ws_q;
        start_i = 1'b0;
        start_q = 1'b0;
        case (mode)
            FRM_MUX: begin
                start_i = fall;
                start_q = rise;
            end
            FRM_PULSE: begin
                start_i = rise;
            end
            default: begin
                start_i = rise | fall;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        ws_q <= ws_d;
    end

endmodule

// File: rtl/bbrx_shreg.sv
// Serial-in shift register holding all but the newest bit of a word.
module bbrx_shreg #(
    parameter int unsigned TAIL_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              din,
    output logic [TAIL_W-1:0] tail
);

    logic [TAIL_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (rst) begin
            sh_d = '0;
        end else if (en) begin
            if (TAIL_W > 1) begin
                sh_d = {sh_q[TAIL_W-2:0], din};
            end else begin
                sh_d = TAIL_W'(din);
            end
        end
    end

    always_ff @(posedge clk) begin
        sh_q <= sh_d;
    end

    assign tail = sh_q;

endmodule

// File: rtl/bbrx_rx.sv
// Serial I/Q baseband deserializer with three selectable framings.
module bbrx_rx
    import bbrx_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic              data_only,
    input  logic              ws,
    input  logic              sd_i,
    input  logic              sd_q,
    output logic              pair_valid,
    output logic [WORD_W-1:0] pair_i,
    output logic [WORD_W-1:0] pair_q,
    output logic              frame_err
);

    localparam int unsigned CNT_W  = $clog2(WORD_W);
    localparam int unsigned TAIL_W = WORD_W - 1;
    localparam int unsigned LANES  = 2;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    typedef struct packed {
        frm_mode_e         cfg_mode;
        logic              cfg_only;
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic              have_i;
        logic [WORD_W-1:0] hold_i;
        logic              valid;
        logic [WORD_W-1:0] out_i;
        logic [WORD_W-1:0] out_q;
        logic              err;
    } st_t;

    st_t st_d, st_q;

    logic              start_i, start_q, marker, is_split;
    logic [LANES-1:0]  lane_en, lane_bit;
    logic [TAIL_W-1:0] lane_tail [LANES];
    logic [WORD_W-1:0] full_i, full_q;

    bbrx_marker u_marker (
        .clk     (clk),
        .mode    (st_q.cfg_mode),
        .ws      (ws),
        .start_i (start_i),
        .start_q (start_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bbrx_shreg #(.TAIL_W(TAIL_W)) u_sh (
            .clk  (clk),
            .rst  (rst),
            .en   (lane_en[g]),
            .din  (lane_bit[g]),
            .tail (lane_tail[g])
        );
    end

    always_comb begin
        is_split = (st_q.cfg_mode == FRM_SPLIT) || (st_q.cfg_mode == FRM_ALT);
        marker   = start_i | start_q;

        lane_bit[0] = sd_i;
        lane_bit[1] = is_split ? sd_q : sd_i;
        lane_en[0]  = !rst && (start_i || (st_q.phase == PH_I && !marker));
        lane_en[1]  = is_split ? lane_en[0]
                    : (!rst && (start_q || (st_q.phase == PH_Q && !marker)));

        full_i = {lane_tail[0], lane_bit[0]};
        full_q = {lane_tail[1], lane_bit[1]};

        st_d       = st_q;
        st_d.valid = 1'b0;

        if (rst) begin
            st_d          = '0;
            st_d.cfg_mode = frm_mode_e'(mode_sel);
            st_d.cfg_only = data_only;
            st_d.phase    = PH_IDLE;
        end else begin
            if (marker && st_q.phase != PH_IDLE && !st_q.cfg_only) begin
                st_d.err = 1'b1;
            end
            if (start_i) begin
                st_d.phase  = PH_I;
                st_d.cnt    = ONE;
                st_d.have_i = 1'b0;
            end else if (start_q) begin
                st_d.phase = PH_Q;
                st_d.cnt   = ONE;
            end else if (st_q.phase == PH_I) begin
                if (st_q.cnt == LAST_BIT) begin
                    if (is_split) begin
                        st_d.valid = 1'b1;
                        st_d.out_i = full_i;
                        st_d.out_q = full_q;
                        st_d.phase = PH_IDLE;
                    end else if (st_q.cfg_mode == FRM_MUX) begin
                        st_d.hold_i = full_i;
                        st_d.have_i = 1'b1;
                        st_d.phase  = PH_IDLE;
                    end else begin
                        st_d.hold_i = full_i;
                        st_d.phase  = PH_Q;
                        st_d.cnt    = '0;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end else if (st_q.phase == PH_Q) begin
                if (st_q.cnt == LAST_BIT) begin
                    if (st_q.cfg_mode == FRM_PULSE || st_q.have_i) begin
                        st_d.valid = 1'b1;
                        st_d.out_i = st_q.hold_i;
                        st_d.out_q = full_q;
                    end
                    st_d.have_i = 1'b0;
                    st_d.phase  = PH_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pair_valid = st_q.valid;
    assign pair_i     = st_q.out_i;
    assign pair_q     = st_q.out_q;
    assign frame_err  = st_q.err;

endmodule

// File: rtl/bbrx_chk.sv
// Temporal checks on the deserializer, bound into every instance.
module bbrx_chk #(
    parameter int unsigned WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              pair_valid,
    input logic [WORD_W-1:0] pair_i,
    input logic [WORD_W-1:0] pair_q,
    input logic              frame_err,
    input logic              cfg_only,
    input logic [1:0]        cfg_mode
);

    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        pair_valid |=> !pair_valid);

    // R5
    pair_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pair_valid |-> ($stable(pair_i) && $stable(pair_q)));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> frame_err);

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_only |-> !frame_err);

    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($stable(cfg_mode) && $stable(cfg_only)));

endmodule

bind bbrx_rx bbrx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pair_valid (pair_valid),
    .pair_i     (pair_i),
    .pair_q     (pair_q),
    .frame_err  (frame_err),
    .cfg_only   (st_q.cfg_only),
    .cfg_mode   (st_q.cfg_mode)
);

// File: tb/bbrx_rx_tb.sv
module bbrx_rx_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'd0;
    logic        data_only = 1'b0;
    logic        ws = 1'b0;
    logic        sd_i = 1'b0;
    logic        sd_q = 1'b0;
    logic        pair_valid;
    logic [15:0] pair_i, pair_q;
    logic        frame_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // mode, I word, Q word
    localparam logic [33:0] VEC [8] = '{
        {2'd0, 16'h1234, 16'hABCD},
        {2'd0, 16'h8000, 16'h7FFF},
        {2'd3, 16'hFFFF, 16'h0000},
        {2'd1, 16'hA5A5, 16'h5A5A},
        {2'd1, 16'h0001, 16'h8000},
        {2'd2, 16'h7FFF, 16'h8001},
        {2'd2, 16'h0000, 16'hFFFF},
        {2'd1, 16'hC3C3, 16'h3C3C}
    };

    always #5 clk = ~clk;

    bbrx_rx u_dut (
        .clk        (clk),
        .rst        (rst),
        .mode_sel   (mode_sel),
        .data_only  (data_only),
        .ws         (ws),
        .sd_i       (sd_i),
        .sd_q       (sd_q),
        .pair_valid (pair_valid),
        .pair_i     (pair_i),
        .pair_q     (pair_q),
        .frame_err  (frame_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m, input logic only, input logic ws_idle);
        rst       = 1'b1;
        mode_sel  = m;
        data_only = only;
        ws        = ws_idle;
        sd_i      = 1'b0;
        sd_q      = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) begin
            sd_i = 1'b0;
            sd_q = 1'b0;
            @(negedge clk);
        end
    endtask

    // Sends one pair in framing m and checks the presented result.
    task automatic send_pair(input logic [1:0] m, input logic [15:0] vi,
                             input logic [15:0] vq);
        string tag;
        tag = (m == 2'd1) ? "R3" : (m == 2'd2) ? "R4" : "R2";
        if (m == 2'd1) begin
            ws = 1'b0;
            for (int k = 0; k < 16; k++) begin
                sd_i = vi[15-k];
                @(negedge clk);
            end
            chk(pair_valid == 1'b0, "R5 no pulse after I only", 32'(pair_valid), 32'd0);
            ws = 1'b1;
            for (int k = 0; k < 16; k++) begin
                sd_i = vq[15-k];
                @(negedge clk);
            end
        end else if (m == 2'd2) begin
            for (int k = 0; k < 32; k++) begin
                ws   = (k == 0);
                sd_i = (k < 16) ? vi[15-k] : vq[31-k];
                @(negedge clk);
            end
        end else begin
            ws = ~ws;
            for (int k = 0; k < 16; k++) begin
                sd_i = vi[15-k];
                sd_q = vq[15-k];
                @(negedge clk);
            end
        end
        chk(pair_valid == 1'b1, {tag, " valid"}, 32'(pair_valid), 32'd1);
        chk(pair_i == vi, {tag, " I word"}, 32'(pair_i), 32'(vi));
        chk(pair_q == vq, {tag, " Q word"}, 32'(pair_q), 32'(vq));
        idle_cycles(1);
        chk(pair_valid == 1'b0, "R5 pulse one cycle", 32'(pair_valid), 32'd0);
        if (m == 2'd0 || m == 2'd3) idle_cycles(15);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset(2'd0, 1'b0, 1'b0);
        chk(pair_valid == 1'b0, "R1 valid", 32'(pair_valid), 32'd0);
        chk(pair_i == 16'h0 && pair_q == 16'h0, "R1 pair", {pair_i, pair_q}, 32'd0);
        chk(frame_err == 1'b0, "R1 err", 32'(frame_err), 32'd0);

        // Table walk: R2, R3, R4, two back-to-back pairs each
        for (int v = 0; v < 8; v++) begin
            do_reset(VEC[v][33:32], 1'b0, VEC[v][33:32] == 2'd1);
            send_pair(VEC[v][33:32], VEC[v][31:16], VEC[v][15:0]);
            send_pair(VEC[v][33:32], ~VEC[v][31:16], ~VEC[v][15:0]);
            chk(frame_err == 1'b0, "R6 no error on clean frames", 32'(frame_err), 32'd0);
        end

        // R6: marker mid-word in split mode
        do_reset(2'd0, 1'b0, 1'b0);
        ws = ~ws;
        for (int k = 0; k < 8; k++) begin
            sd_i = 1'b1;
            sd_q = 1'b1;
            @(negedge clk);
            chk(pair_valid == 1'b0, "R6 no pair from partial", 32'(pair_valid), 32'd0);
        end
        send_pair(2'd0, 16'h1357, 16'h8642);
        chk(frame_err == 1'b1, "R6 err set", 32'(frame_err), 32'd1);
        send_pair(2'd0, 16'h0F0F, 16'hF0F0);
        chk(frame_err == 1'b1, "R6 err sticky", 32'(frame_err), 32'd1);
        do_reset(2'd0, 1'b0, 1'b0);
        chk(frame_err == 1'b0, "R1 err cleared by reset", 32'(frame_err), 32'd0);

        // R8: same fault with data_only captured
        do_reset(2'd0, 1'b1, 1'b0);
        ws = ~ws;
        idle_cycles(8);
        send_pair(2'd0, 16'h2468, 16'h9BDF);
        chk(frame_err == 1'b0, "R8 err suppressed", 32'(frame_err), 32'd0);

        // R7: Q word with no I word before it in multiplexed mode
        do_reset(2'd1, 1'b0, 1'b0);
        ws = 1'b1;
        for (int k = 0; k < 16; k++) begin
            sd_i = 1'b1;
            @(negedge clk);
        end
        chk(pair_valid == 1'b0, "R7 orphan Q dropped", 32'(pair_valid), 32'd0);
        chk(pair_i == 16'h0 && pair_q == 16'h0, "R7 pair untouched", {pair_i, pair_q}, 32'd0);
        send_pair(2'd1, 16'h4321, 16'hFEDC);
        chk(frame_err == 1'b0, "R7 no error", 32'(frame_err), 32'd0);

        // R9: configuration changes after reset are ignored
        do_reset(2'd2, 1'b0, 1'b0);
        mode_sel  = 2'd0;
        data_only = 1'b1;
        send_pair(2'd2, 16'h5555, 16'hAAAA);
        ws = 1'b1;
        sd_i = 1'b0;
        @(negedge clk);
        ws = 1'b0;
        idle_cycles(7);
        send_pair(2'd2, 16'h1111, 16'h2222);
        chk(frame_err == 1'b1, "R9 data_only change ignored", 32'(frame_err), 32'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule